// File: doc/BRIEF.md
# Host Controller Command and Status Unit

This block is the central register set of a full/low-speed USB host controller. It holds the command word, the status word, the interrupt-enable mask, an 11-bit frame counter and the frame-list base pointer. It also starts and stops the frame sequencer. An external 1 kHz strobe advances the frame counter while the controller runs. The block supplies the address of the current frame-list entry to the schedule walker, which sits outside this block.

The schedule walker reports per-frame events to the block as single-cycle pulses. Completion events (transfer-done-with-interrupt and short-packet) are collected during a frame and reach the status word only at the next frame boundary. They are kept in a hidden two-bit cause register, so the two can be masked apart. Error, resume and fault events take effect at once. A single level interrupt line combines the status bits with the enable mask.

Top module: `hc_cmd_status`

## Requirements
- R1: After reset: command reads 0, status reads 0x0020 (only halted, bit 5, set), enable reads 0, frame number reads 0, base reads 0, `irq` is 0 and `list_addr` is 0.
- R2: Writing the command word with run (bit 0) going from 0 to 1 clears halted and enables frame ticks. Each tick then raises the frame number by one, wrapping from 2047 to 0.
- R3: Writing run as 0 sets halted at once. A tick that sees run at 0 stops ticking, and later ticks leave the frame number unchanged.
- R4: A frame-number write (offset 6) keeps the low 11 bits and takes effect only while halted. While running it is ignored.
- R5: A base write (offset 8, 32 bits) keeps bits 31:12, and bits 11:0 read as 0. `list_addr` equals base plus four times the low 10 bits of the frame number.
- R6: Completion events are deferred. An IOC pulse sets hidden cause bit 0 and a short-packet pulse sets hidden cause bit 1, both at the next advancing tick and not before. That tick also sets status bit 0. Cause bit 0 drives `irq` when enable bit 2 is set, and cause bit 1 drives it when enable bit 3 is set.
- R7: An error pulse sets status bit 1, which drives `irq` when enable bit 0 is set. A host-error pulse sets status bit 3 and a process-error pulse sets status bit 4. Both drive `irq` with no enable.
- R8: A resume pulse while suspend (command bit 3) is set sets force-resume (command bit 4) and resume-detect (status bit 2). Resume-detect drives `irq` when enable bit 1 is set. Without suspend, a resume pulse has no effect.
- R9: Status bits 4:0 are cleared by writing 1 to them. Writing 1 to bit 0 also clears both hidden cause bits, so `irq` from completions drops.
- R10: Writing command bit 1 resets the unit in the same clock: command, enable, frame number, base and causes return to 0, and status becomes 0x0020. Bit 1 reads back as 0.
- R11: A read at offsets 0/2/4/6/8 returns command/status/enable/frame number/base on `reg_rdata` one clock after `reg_rd`, zero-extended. Other offsets read 0. `irq` follows a state change by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| frame_tick | input | 1 | 1 kHz frame strobe, one cycle |
| ev_ioc | input | 1 | Transfer completed with interrupt request |
| ev_short | input | 1 | Short packet ended a transfer |
| ev_err | input | 1 | Transfer error |
| ev_resume | input | 1 | Remote resume signalled |
| ev_host_err | input | 1 | Host system error |
| ev_proc_err | input | 1 | Schedule processing error |
| irq | output | 1 | Level interrupt, registered |
| list_addr | output | 32 | Current frame-list entry address |
| frame_run | output | 1 | Frame ticks are being accepted |

## Verification
A wrong frame counter shows on `list_addr` in the clock after the tick, and in the frame-number read one clock later. A lost or early completion cause shows as `irq` asserting before the next tick, or staying low one clock after it. This is visible whether or not status bit 0 reads correctly. A halted flag that disagrees with the run bit shows as ticks that advance the frame number while stopped, or as frame-number writes that are accepted while running.

// File: rtl/hc_cs_pkg.sv
package hc_cs_pkg;
  localparam int OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_CMD  = 4'h0;
  localparam logic [OFS_W-1:0] OFS_STS  = 4'h2;
  localparam logic [OFS_W-1:0] OFS_IEN  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_FNUM = 4'h6;
  localparam logic [OFS_W-1:0] OFS_BASE = 4'h8;

  // command word bit positions
  localparam int CMD_RUN  = 0;
  localparam int CMD_HRST = 1;
  localparam int CMD_GRST = 2;
  localparam int CMD_SUSP = 3;
  localparam int CMD_FRES = 4;
  localparam int CMD_W    = 5;

  // status word bit positions
  localparam int STS_INT  = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_RES  = 2;
  localparam int STS_HSE  = 3;
  localparam int STS_PE   = 4;
  localparam int STS_HALT = 5;
  localparam int STS_W    = 6;

  // enable mask bit positions
  localparam int IEN_ERR = 0;
  localparam int IEN_RES = 1;
  localparam int IEN_IOC = 2;
  localparam int IEN_SPK = 3;
  localparam int IEN_W   = 4;

  // hidden completion causes: bit 0 IOC, bit 1 short packet
  typedef logic [1:0] cause_t;
endpackage

// File: rtl/hc_frame_seq.sv
module hc_frame_seq #(
  parameter int FNUM_W = 11
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              tick,
  input  logic              run_bit,
  input  logic              run_rise,
  input  logic              ld_en,
  input  logic [FNUM_W-1:0] ld_val,
  output logic [FNUM_W-1:0] fnum,
  output logic              tick_en,
  output logic              adv,
  output logic              stop
);
  assign adv  = tick && tick_en && run_bit;
  assign stop = tick && tick_en && !run_bit;

  always_ff @(posedge clk) begin
    if (clr) begin
      fnum    <= '0;
      tick_en <= 1'b0;
    end else begin
      if (run_rise)  tick_en <= 1'b1;
      else if (stop) tick_en <= 1'b0;
      if (adv)        fnum <= fnum + 1'b1;
      else if (ld_en) fnum <= ld_val;
    end
  end
endmodule

// File: rtl/hc_cause_latch.sv
module hc_cause_latch
  import hc_cs_pkg::*;
(
  input  logic   clk,
  input  logic   clr,
  input  logic   ev_ioc,
  input  logic   ev_short,
  input  logic   adv,
  input  logic   ack,
  output cause_t cause,
  output logic   raise
);
  cause_t pend_q;
  cause_t evt;

  assign evt   = {ev_short, ev_ioc};
  assign raise = adv && (pend_q != '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      pend_q <= '0;
      cause  <= '0;
    end else begin
      pend_q <= adv ? evt : (pend_q | evt);
      cause  <= (ack ? cause_t'(0) : cause) | (adv ? pend_q : cause_t'(0));
    end
  end
endmodule

// File: rtl/hc_irq_gen.sv
module hc_irq_gen
  import hc_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cause_t           cause,
  input  logic [STS_W-1:0] status,
  input  logic [IEN_W-1:0] ien,
  output logic             irq
);
  logic level;

  assign level = (cause[0] && ien[IEN_IOC]) ||
                 (cause[1] && ien[IEN_SPK]) ||
                 (status[STS_ERR] && ien[IEN_ERR]) ||
                 (status[STS_RES] && ien[IEN_RES]) ||
                 status[STS_HSE] || status[STS_PE];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= level;
  end
endmodule

// File: rtl/hc_cmd_status.sv
module hc_cmd_status
  import hc_cs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FNUM_W      = 11,
  parameter int IDX_W       = 10,
  parameter int BASE_LSB    = 12,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_tick,
  input  logic              ev_ioc,
  input  logic              ev_short,
  input  logic              ev_err,
  input  logic              ev_resume,
  input  logic              ev_host_err,
  input  logic              ev_proc_err,
  output logic              irq,
  output logic [DATA_W-1:0] list_addr,
  output logic              frame_run
);
  localparam logic [STS_W-1:0] STS_AT_RST = STS_W'(1) << STS_HALT;
  localparam int BASE_W = DATA_W - BASE_LSB;

  logic [CMD_W-1:0]  cmd_q,  cmd_d;
  logic [STS_W-1:0]  status_q, sts_d;
  logic [IEN_W-1:0]  ien_q;
  logic [BASE_W-1:0] base_q;
  logic [FNUM_W-1:0] fnum_q;
  cause_t            cause_q;
  logic              tick_en;

  logic wr_cmd, wr_sts, wr_ien, wr_fnum, wr_base;
  logic hc_rst, rs_rise, rs_drop_wr, resume_hit;
  logic frame_adv, stop_evt, usbint_set;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata;

  assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
  assign wr_sts  = reg_wr && (reg_addr == OFS_STS);
  assign wr_ien  = reg_wr && (reg_addr == OFS_IEN);
  assign wr_fnum = reg_wr && (reg_addr == OFS_FNUM);
  assign wr_base = reg_wr && (reg_addr == OFS_BASE);

  assign hc_rst     = rst || (wr_cmd && reg_wdata[CMD_HRST]);
  assign rs_rise    = wr_cmd && reg_wdata[CMD_RUN] && !cmd_q[CMD_RUN];
  assign rs_drop_wr = wr_cmd && !reg_wdata[CMD_RUN];
  assign resume_hit = ev_resume && cmd_q[CMD_SUSP];

  hc_frame_seq #(.FNUM_W(FNUM_W)) u_seq (
    .clk      (clk),
    .clr      (hc_rst),
    .tick     (frame_tick),
    .run_bit  (cmd_q[CMD_RUN]),
    .run_rise (rs_rise),
    .ld_en    (wr_fnum && status_q[STS_HALT]),
    .ld_val   (reg_wdata[FNUM_W-1:0]),
    .fnum     (fnum_q),
    .tick_en  (tick_en),
    .adv      (frame_adv),
    .stop     (stop_evt)
  );

  hc_cause_latch u_cause (
    .clk      (clk),
    .clr      (hc_rst),
    .ev_ioc   (ev_ioc),
    .ev_short (ev_short),
    .adv      (frame_adv),
    .ack      (wr_sts && reg_wdata[STS_INT]),
    .cause    (cause_q),
    .raise    (usbint_set)
  );

  hc_irq_gen u_irq (
    .clk    (clk),
    .rst    (rst),
    .cause  (cause_q),
    .status (status_q),
    .ien    (ien_q),
    .irq    (irq)
  );

  always_comb begin
    cmd_d = cmd_q;
    if (wr_cmd) begin
      cmd_d           = reg_wdata[CMD_W-1:0];
      cmd_d[CMD_HRST] = 1'b0;
    end
    if (resume_hit) cmd_d[CMD_FRES] = 1'b1;
  end

  always_comb begin
    sts_d = status_q;
    if (wr_sts)
      sts_d[STS_PE:STS_INT] = status_q[STS_PE:STS_INT] & ~reg_wdata[STS_PE:STS_INT];
    if (usbint_set)  sts_d[STS_INT] = 1'b1;
    if (ev_err)      sts_d[STS_ERR] = 1'b1;
    if (resume_hit)  sts_d[STS_RES] = 1'b1;
    if (ev_host_err) sts_d[STS_HSE] = 1'b1;
    if (ev_proc_err) sts_d[STS_PE]  = 1'b1;
    if (rs_drop_wr || stop_evt) sts_d[STS_HALT] = 1'b1;
    if (rs_rise)                sts_d[STS_HALT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (hc_rst) begin
      cmd_q    <= '0;
      status_q <= STS_AT_RST;
      ien_q    <= '0;
      base_q   <= '0;
    end else begin
      cmd_q    <= cmd_d;
      status_q <= sts_d;
      if (wr_ien)  ien_q  <= reg_wdata[IEN_W-1:0];
      if (wr_base) base_q <= reg_wdata[DATA_W-1:BASE_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CMD:  reg_rdata <= DATA_W'(cmd_q);
        OFS_STS:  reg_rdata <= DATA_W'(status_q);
        OFS_IEN:  reg_rdata <= DATA_W'(ien_q);
        OFS_FNUM: reg_rdata <= DATA_W'(fnum_q);
        OFS_BASE: reg_rdata <= {base_q, {BASE_LSB{1'b0}}};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign list_addr = {base_q, {BASE_LSB{1'b0}}} +
                     (DATA_W'(fnum_q[IDX_W-1:0]) << ENTRY_SHIFT);
  assign frame_run = tick_en;
endmodule

// File: rtl/hc_cmd_status_chk.sv
module hc_cmd_status_chk
  import hc_cs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FNUM_W   = 11,
  parameter int BASE_LSB = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [OFS_W-1:0]  reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              frame_tick,
  input logic              irq,
  input logic [CMD_W-1:0]  cmd_q,
  input logic [STS_W-1:0]  status_q,
  input logic [FNUM_W-1:0] fnum_q,
  input logic              tick_en
);
  logic cmd_wr;
  assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);

  assert_fnum_step_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && tick_en && cmd_q[CMD_RUN] && !reg_wr)
      |=> (fnum_q == FNUM_W'($past(fnum_q) + 1'b1)));

  assert_run_clears_halt_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && reg_wdata[CMD_RUN] && !reg_wdata[CMD_HRST] && !cmd_q[CMD_RUN])
      |=> (!status_q[STS_HALT] && tick_en));

  assert_stop_sets_halt_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !reg_wdata[CMD_RUN]) |=> status_q[STS_HALT]);

  assert_fnum_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!frame_tick && !reg_wr) |=> $stable(fnum_q));

  assert_base_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_BASE) |=> (reg_rdata[BASE_LSB-1:0] == '0));

  assert_fault_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q[STS_HSE] || status_q[STS_PE]) |=> irq);

  assert_hc_reset_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && reg_wdata[CMD_HRST])
      |=> (cmd_q == '0 && status_q == (STS_W'(1) << STS_HALT) && fnum_q == '0));
endmodule

bind hc_cmd_status hc_cmd_status_chk #(
  .DATA_W(DATA_W), .FNUM_W(FNUM_W), .BASE_LSB(BASE_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .frame_tick (frame_tick),
  .irq        (irq),
  .cmd_q      (cmd_q),
  .status_q   (status_q),
  .fnum_q     (fnum_q),
  .tick_en    (tick_en)
);

// File: tb/tb_hc_cmd_status.sv
module tb_hc_cmd_status;
  import hc_cs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_tick = 1'b0;
  logic        ev_ioc = 1'b0, ev_short = 1'b0, ev_err = 1'b0;
  logic        ev_resume = 1'b0, ev_host_err = 1'b0, ev_proc_err = 1'b0;
  logic        irq;
  logic [31:0] list_addr;
  logic        frame_run;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_cmd_status dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_tick(frame_tick), .ev_ioc(ev_ioc), .ev_short(ev_short),
    .ev_err(ev_err), .ev_resume(ev_resume), .ev_host_err(ev_host_err),
    .ev_proc_err(ev_proc_err), .irq(irq), .list_addr(list_addr),
    .frame_run(frame_run)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  // which: 0 ioc, 1 short, 2 err, 3 resume, 4 host err, 5 proc err
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_ioc = 1'b1;
      1: ev_short = 1'b1;
      2: ev_err = 1'b1;
      3: ev_resume = 1'b1;
      4: ev_host_err = 1'b1;
      default: ev_proc_err = 1'b1;
    endcase
    @(negedge clk);
    {ev_ioc, ev_short, ev_err, ev_resume, ev_host_err, ev_proc_err} = '0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(OFS_CMD, v);  chk("R1 cmd at reset", v, 32'h0);
    rd(OFS_STS, v);  chk("R1 status at reset", v, 32'h20);
    rd(OFS_IEN, v);  chk("R1 enable at reset", v, 32'h0);
    rd(OFS_FNUM, v); chk("R1 fnum at reset", v, 32'h0);
    rd(OFS_BASE, v); chk("R1 base at reset", v, 32'h0);
    chk("R1 irq at reset", {31'b0, irq}, 32'h0);
    chk("R1 list_addr at reset", list_addr, 32'h0);
  endtask

  task automatic t_run();
    logic [31:0] v;
    wr(OFS_BASE, 32'h1234_5ABC);
    rd(OFS_BASE, v); chk("R5 base low bits dropped", v, 32'h1234_5000);
    wr(OFS_FNUM, 32'h0000_FFFE);
    rd(OFS_FNUM, v); chk("R4 fnum write while halted", v, 32'h7FE);
    chk("R5 list_addr uses low 10 bits", list_addr, 32'h1234_5FF8);
    tick();
    rd(OFS_FNUM, v); chk("R3 tick while halted ignored", v, 32'h7FE);
    wr(OFS_CMD, 32'h1);
    rd(OFS_STS, v); chk("R2 run clears halted", v, 32'h0);
    chk("R2 frame_run after start", {31'b0, frame_run}, 32'h1);
    tick();
    rd(OFS_FNUM, v); chk("R2 fnum increments", v, 32'h7FF);
    chk("R5 list_addr follows fnum", list_addr, 32'h1234_5FFC);
    tick();
    rd(OFS_FNUM, v); chk("R2 fnum wraps to 0", v, 32'h0);
    wr(OFS_FNUM, 32'h5);
    rd(OFS_FNUM, v); chk("R4 fnum write while running ignored", v, 32'h0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(OFS_CMD, 32'h0);
    rd(OFS_STS, v); chk("R3 run=0 sets halted", v, 32'h20);
    tick(); tick();
    rd(OFS_FNUM, v); chk("R3 no advance after stop", v, 32'h0);
    chk("R3 frame_run low after stop tick", {31'b0, frame_run}, 32'h0);
    wr(OFS_CMD, 32'h1);
    tick();
    rd(OFS_FNUM, v); chk("R2 restart advances", v, 32'h1);
  endtask

  task automatic t_defer();
    logic [31:0] v;
    wr(OFS_IEN, 32'h4);
    pulse(0);
    rd(OFS_STS, v); chk("R6 IOC not shown before tick", v, 32'h0);
    chk("R6 no irq before tick", {31'b0, irq}, 32'h0);
    tick();
    rd(OFS_STS, v); chk("R6 status int after tick", v, 32'h1);
    chk("R6 irq from IOC cause", {31'b0, irq}, 32'h1);
    wr(OFS_STS, 32'h1);
    settle();
    rd(OFS_STS, v); chk("R9 status int cleared", v, 32'h0);
    chk("R9 irq drops after ack", {31'b0, irq}, 32'h0);
    pulse(1);
    tick();
    rd(OFS_STS, v); chk("R6 short packet status int", v, 32'h1);
    chk("R6 short cause masked by IOC-only enable", {31'b0, irq}, 32'h0);
    wr(OFS_IEN, 32'h8);
    settle();
    chk("R6 short cause with enable bit 3", {31'b0, irq}, 32'h1);
    wr(OFS_STS, 32'h1);
    settle();
    chk("R9 short cause cleared by ack", {31'b0, irq}, 32'h0);
    wr(OFS_IEN, 32'h0);
  endtask

  task automatic t_errs();
    logic [31:0] v;
    pulse(2);
    rd(OFS_STS, v); chk("R7 error status bit", v, 32'h2);
    chk("R7 error masked", {31'b0, irq}, 32'h0);
    wr(OFS_IEN, 32'h1);
    settle();
    chk("R7 error enabled irq", {31'b0, irq}, 32'h1);
    wr(OFS_STS, 32'h2);
    settle();
    chk("R9 error cleared irq", {31'b0, irq}, 32'h0);
    wr(OFS_IEN, 32'h0);
    pulse(4);
    rd(OFS_STS, v); chk("R7 host error status bit", v, 32'h8);
    chk("R7 host error unmasked irq", {31'b0, irq}, 32'h1);
    wr(OFS_STS, 32'h8);
    pulse(5);
    rd(OFS_STS, v); chk("R7 process error status bit", v, 32'h10);
    chk("R7 process error unmasked irq", {31'b0, irq}, 32'h1);
    wr(OFS_STS, 32'h10);
    rd(OFS_STS, v); chk("R9 all status cleared", v, 32'h0);
    chk("R9 irq low after clears", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_resume();
    logic [31:0] v;
    pulse(3);
    rd(OFS_CMD, v); chk("R8 resume ignored without suspend (cmd)", v, 32'h1);
    rd(OFS_STS, v); chk("R8 resume ignored without suspend (status)", v, 32'h0);
    wr(OFS_CMD, 32'h9);
    pulse(3);
    rd(OFS_CMD, v); chk("R8 force resume set", v, 32'h19);
    rd(OFS_STS, v); chk("R8 resume detect set", v, 32'h4);
    wr(OFS_IEN, 32'h2);
    settle();
    chk("R8 resume irq with enable bit 1", {31'b0, irq}, 32'h1);
    wr(OFS_STS, 32'h4);
    wr(OFS_IEN, 32'h0);
    wr(OFS_CMD, 32'h1);
  endtask

  task automatic t_hcreset();
    logic [31:0] v;
    wr(OFS_IEN, 32'hF);
    pulse(4);
    tick();
    wr(OFS_CMD, 32'h3);
    settle();
    rd(OFS_CMD, v);  chk("R10 cmd cleared", v, 32'h0);
    rd(OFS_STS, v);  chk("R10 status halted only", v, 32'h20);
    rd(OFS_IEN, v);  chk("R10 enable cleared", v, 32'h0);
    rd(OFS_FNUM, v); chk("R10 fnum cleared", v, 32'h0);
    rd(OFS_BASE, v); chk("R10 base cleared", v, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    chk("R10 list_addr cleared", list_addr, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(4'hE, v); chk("R11 unmapped offset reads 0", v, 32'h0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_run();
    t_stop();
    t_defer();
    t_errs();
    t_resume();
    t_hcreset();
    t_unmapped();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule